// File: doc/BRIEF.md
# Two-Clock Mailbox Register

This block passes a single 36-bit word from a producer running on one clock to a consumer running on an unrelated clock. The word sits in one holding register. A status flag guards it and is active low while a word is waiting. The producer offers a word by selecting the mailbox with its direction input set to write. The consumer takes the word by selecting the mailbox with its direction input set to read. Each side sees its own copy of the flag, registered in its own clock domain.

The flag is built as a toggle handshake. An accepted write flips a producer-side toggle, and an accepted read flips a consumer-side toggle. Each toggle reaches the other domain through a chain of synchronizer flops, two by default. The producer cannot store again until the consumer's toggle has come back. Because of that, the holding register never changes while the consumer is sampling it.

A synchronous, active-high reset empties the mailbox in both domains. The reset must be held across several rising edges of both clocks.

Top module: `mbx_cdc_mailbox`

## Requirements
- R1: While `rst` is high, each rising edge of either clock leaves `wr_flag_n` high, `rd_flag_n` high and `rd_data` at zero.
- R2: A `wr_clk` edge with `wr_sel`=1, `wr_dir`=1 and `wr_flag_n`=1 stores `wr_data` and drives `wr_flag_n` low on that same edge.
- R3: While `wr_flag_n` is low, a write request is ignored. The stored word is not replaced and no extra word is delivered.
- R4: A `wr_clk` edge with `wr_sel`=0, or with `wr_dir`=0, stores nothing.
- R5: On the second `rd_clk` edge after an accepted write edge, `rd_flag_n` goes low and `rd_data` shows the stored word.
- R6: An `rd_clk` edge with `rd_sel`=1, `rd_dir`=0 and `rd_flag_n`=0 is an accepted read. It drives `rd_flag_n` high on that edge.
- R7: `wr_flag_n` returns high on the second `wr_clk` edge after an accepted read edge. Only then can the next write be accepted.
- R8: A read request while `rd_flag_n` is high has no effect. So does an edge with `rd_sel`=0 or `rd_dir`=1. A pending word stays pending until it is read.
- R9: Reading does not clear `rd_data`. It holds the last delivered word until the next accepted write arrives.
- R10: Every accepted word reaches `rd_data` exactly once, in write order, whatever the ratio of the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock, asynchronous to `wr_clk` |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_sel | input | 1 | Producer selects the mailbox |
| wr_dir | input | 1 | Producer direction, 1 = write, 0 = read |
| wr_data | input | 36 | Word offered by the producer |
| wr_flag_n | output | 1 | Producer view of the flag, low = word waiting |
| rd_sel | input | 1 | Consumer selects the mailbox |
| rd_dir | input | 1 | Consumer direction, 1 = write, 0 = read |
| rd_data | output | 36 | Last word delivered to the consumer domain |
| rd_flag_n | output | 1 | Consumer view of the flag, low = word waiting |

## Verification
Some rules hold locally within one clock domain, and the assertions check these on every cycle. An accepted write lowers the producer flag. A blocked write leaves the holding register unchanged. An accepted read raises the consumer flag without disturbing `rd_data`. An idle consumer keeps a pending word pending.

The two-edge synchronizer latency in each direction involves both clocks, and so does the guarantee that no word is lost or delivered twice. Only the bench's scenarios can show these. It runs three clock ratios against an event-counting model that predicts both flags and the read data on every edge.

// File: rtl/mbx_pkg.sv
`timescale 1ns/100ps
package mbx_pkg;
  parameter int unsigned MBX_DATA_W      = 36;
  parameter int unsigned MBX_SYNC_STAGES = 2;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } mbx_dir_e;
endpackage

// File: rtl/mbx_toggle_sync.sv
`timescale 1ns/100ps
module mbx_toggle_sync #(
  parameter int unsigned STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_i,
  output logic tog_o,
  output logic tog_next_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[LAST-1:0], tog_i};
    end
  end

  assign tog_o      = stg_q[LAST];
  assign tog_next_o = stg_q[LAST-1];
endmodule

// File: rtl/mbx_wr_side.sv
`timescale 1ns/100ps
module mbx_wr_side #(
  parameter int unsigned DATA_W = mbx_pkg::MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              peer_tog_next_i,
  output logic              tog_o,
  output logic              flag_n_o,
  output logic [DATA_W-1:0] hold_o
);
  import mbx_pkg::*;

  logic              tog_q;
  logic              flag_n_q;
  logic [DATA_W-1:0] hold_q;
  logic              wr_req;
  logic              wr_take;
  logic              tog_d;

  assign wr_req  = sel_i && (mbx_dir_e'(dir_i) == DIR_WRITE);
  assign wr_take = wr_req && flag_n_q;
  assign tog_d   = tog_q ^ wr_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q    <= 1'b0;
      flag_n_q <= 1'b1;
      hold_q   <= '0;
    end else begin
      tog_q    <= tog_d;
      flag_n_q <= (tog_d == peer_tog_next_i);
      if (wr_take) begin
        hold_q <= data_i;
      end
    end
  end

  assign tog_o    = tog_q;
  assign flag_n_o = flag_n_q;
  assign hold_o   = hold_q;

  // R2: an accepted write marks the mailbox full on the following cycle
  p_write_marks_full_r2: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> !flag_n_q);

  // R3: a write attempted while full leaves the held word untouched
  p_blocked_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !flag_n_q) |=> $stable(hold_q));
endmodule

// File: rtl/mbx_rd_side.sv
`timescale 1ns/100ps
module mbx_rd_side #(
  parameter int unsigned DATA_W = mbx_pkg::MBX_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              dir_i,
  input  logic              peer_tog_i,
  input  logic              peer_tog_next_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              tog_o,
  output logic              flag_n_o,
  output logic [DATA_W-1:0] data_o
);
  import mbx_pkg::*;

  logic              tog_q;
  logic              flag_n_q;
  logic [DATA_W-1:0] data_q;
  logic              rd_take;
  logic              tog_d;
  logic              arrive;

  assign rd_take = sel_i && (mbx_dir_e'(dir_i) == DIR_READ) && !flag_n_q;
  assign tog_d   = tog_q ^ rd_take;
  assign arrive  = (peer_tog_next_i != peer_tog_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q    <= 1'b0;
      flag_n_q <= 1'b1;
      data_q   <= '0;
    end else begin
      tog_q    <= tog_d;
      flag_n_q <= (peer_tog_next_i == tog_d);
      if (arrive) begin
        data_q <= hold_i;
      end
    end
  end

  assign tog_o    = tog_q;
  assign flag_n_o = flag_n_q;
  assign data_o   = data_q;

  // R6: an accepted read empties the consumer view
  p_read_empties_r6: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> flag_n_q);

  // R8: without an accepted read a pending word stays pending
  p_pending_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (!flag_n_q && !rd_take) |=> !flag_n_q);

  // R9: reading leaves the delivered word in place
  p_read_keeps_data_r9: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> $stable(data_q));
endmodule

// File: rtl/mbx_cdc_mailbox.sv
`timescale 1ns/100ps
module mbx_cdc_mailbox #(
  parameter int unsigned DATA_W      = mbx_pkg::MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              wr_dir,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_flag_n,
  input  logic              rd_sel,
  input  logic              rd_dir,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag_n
);
  logic              w_tog;
  logic              r_tog;
  logic              w_tog_at_r;
  logic              w_tog_at_r_next;
  logic              r_tog_at_w;
  logic              r_tog_at_w_next;
  logic [DATA_W-1:0] hold;

  mbx_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk             (wr_clk),
    .rst             (rst),
    .sel_i           (wr_sel),
    .dir_i           (wr_dir),
    .data_i          (wr_data),
    .peer_tog_next_i (r_tog_at_w_next),
    .tog_o           (w_tog),
    .flag_n_o        (wr_flag_n),
    .hold_o          (hold)
  );

  mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk        (wr_clk),
    .rst        (rst),
    .tog_i      (r_tog),
    .tog_o      (r_tog_at_w),
    .tog_next_o (r_tog_at_w_next)
  );

  mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk        (rd_clk),
    .rst        (rst),
    .tog_i      (w_tog),
    .tog_o      (w_tog_at_r),
    .tog_next_o (w_tog_at_r_next)
  );

  mbx_rd_side #(.DATA_W(DATA_W)) u_rd (
    .clk             (rd_clk),
    .rst             (rst),
    .sel_i           (rd_sel),
    .dir_i           (rd_dir),
    .peer_tog_i      (w_tog_at_r),
    .peer_tog_next_i (w_tog_at_r_next),
    .hold_i          (hold),
    .tog_o           (r_tog),
    .flag_n_o        (rd_flag_n),
    .data_o          (rd_data)
  );

  // R7: the producer flag is never empty while its toggle is unanswered
  p_full_until_return_r7: assert property (@(posedge wr_clk) disable iff (rst)
    (w_tog != r_tog_at_w) |-> !wr_flag_n);
endmodule

// File: tb/test_mbx_cdc_mailbox.sv
`timescale 1ns/100ps
module test_mbx_cdc_mailbox;
  localparam int  DW        = 36;
  localparam real WR_PERIOD = 10.0;
  localparam int  PHASE_CYC = 1500;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_sel = 1'b0;
  logic          wr_dir = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic          rd_dir = 1'b1;
  logic          wr_flag_n;
  logic          rd_flag_n;
  logic [DW-1:0] rd_data;

  int rd_half = 7;
  int rd_mode = 0;
  int checks = 0;
  int fails = 0;

  mbx_cdc_mailbox i_mbx_cdc_mailbox (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
    .wr_sel(wr_sel), .wr_dir(wr_dir), .wr_data(wr_data), .wr_flag_n(wr_flag_n),
    .rd_sel(rd_sel), .rd_dir(rd_dir), .rd_data(rd_data), .rd_flag_n(rd_flag_n)
  );

  always #(WR_PERIOD / 2.0) wr_clk = ~wr_clk;
  initial begin
    #2.3;
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural event-count model
  logic [DW-1:0] words[$];
  int  wr_cnt = 0, rd_cnt = 0;
  int  ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
  int  blocked = 0;
  bit  w_arm = 0, r_arm = 0;
  bit  w_take, r_take;
  logic          exp_wf = 1'b1, exp_rf = 1'b1;
  logic [DW-1:0] exp_rd = '0;

  always begin
    @(posedge wr_clk);
    if (rst) begin
      wr_cnt = 0; ws1 = 0; ws2 = 0; words.delete(); w_arm = 1;
    end else begin
      w_take = wr_sel && wr_dir && (wr_cnt <= ws2);
      if (wr_sel && wr_dir && !w_take) blocked++;
      ws2 = ws1;
      ws1 = rd_cnt;
      if (w_take) begin
        words.push_back(wr_data);
        wr_cnt++;
      end
    end
    exp_wf = !(wr_cnt > ws2);
    #1;
    if (w_arm) chk(rst ? "R1 wr_flag_n" : "R2/R3/R4/R7 wr_flag_n", DW'(wr_flag_n), DW'(exp_wf));
  end

  always begin
    int old;
    @(posedge rd_clk);
    if (rst) begin
      rd_cnt = 0; rs1 = 0; rs2 = 0; exp_rd = '0; r_arm = 1;
    end else begin
      r_take = rd_sel && !rd_dir && (rs2 > rd_cnt);
      if (r_take) rd_cnt++;
      old = rs2;
      rs2 = rs1;
      rs1 = wr_cnt;
      if (rs2 > old) exp_rd = words[rs2-1];
    end
    exp_rf = !(rs2 > rd_cnt);
    #1;
    if (r_arm) begin
      chk(rst ? "R1 rd_flag_n" : "R5/R6/R8 rd_flag_n", DW'(rd_flag_n), DW'(exp_rf));
      chk(rst ? "R1 rd_data" : "R5/R9/R10 rd_data", rd_data, exp_rd);
    end
  end

  // consumer stimulus: 0 = random mix, 1 = read always, 2 = idle
  always @(negedge rd_clk) begin
    if (rd_mode == 0) begin
      rd_sel <= ($urandom_range(99) < 50);
      rd_dir <= ($urandom_range(99) < 30);
    end else if (rd_mode == 1) begin
      rd_sel <= 1'b1;
      rd_dir <= 1'b0;
    end else begin
      rd_sel <= 1'b0;
      rd_dir <= 1'b1;
    end
  end

  task automatic wr_phase(input int cycles, input int sel_pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge wr_clk);
      wr_sel  <= ($urandom_range(99) < sel_pct);
      wr_dir  <= ($urandom_range(99) < 80);
      wr_data <= {4'($urandom()), $urandom()};
    end
  endtask

  initial begin
    rd_mode = 2;
    repeat (8) @(negedge wr_clk);
    rst <= 1'b0;
    repeat (4) @(negedge wr_clk);
    // R1: reset state seen after release, before any traffic
    chk("R1 idle wr_flag_n", DW'(wr_flag_n), DW'(1'b1));
    chk("R1 idle rd_flag_n", DW'(rd_flag_n), DW'(1'b1));
    chk("R1 idle rd_data", rd_data, '0);
    // R4: producer reads and deselected writes store nothing
    for (int i = 0; i < 20; i++) begin
      @(negedge wr_clk);
      wr_sel <= (i % 2 == 0); wr_dir <= (i % 2 != 0); wr_data <= {4'($urandom()), $urandom()};
    end
    @(negedge wr_clk); wr_sel <= 1'b0;
    repeat (10) @(negedge wr_clk);
    chk("R4 no word after non-writes", DW'(rd_flag_n), DW'(1'b1));
    rd_mode = 0; rd_half = 7;  wr_phase(PHASE_CYC, 70);
    rd_half = 23;               wr_phase(PHASE_CYC, 90);
    rd_half = 3;                wr_phase(PHASE_CYC, 60);
    @(negedge wr_clk); wr_sel <= 1'b0;
    rd_mode = 1;
    repeat (300) @(negedge wr_clk);
    chk("R10 every write delivered", DW'(rd_cnt), DW'(wr_cnt));
    chk("R2 writes were accepted", DW'(wr_cnt > 50), DW'(1'b1));
    chk("R3 blocked writes occurred", DW'(blocked > 0), DW'(1'b1));
    chk("R7 producer flag empty after drain", DW'(wr_flag_n), DW'(1'b1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(WR_PERIOD * 100000.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule